// File: doc/BRIEF.md
# Host Port Interrupt Prioritizer

This block is the processor-side control logic of a parallel host port. The local core programs one control word that holds the DMA enables, two general-purpose flags shown to the host, and three interrupt enables. The core also programs a vector register for host commands. The block combines these settings with three status inputs: command pending, transmit register empty and receive register full. From them it produces one registered interrupt request with a vector, chosen by a fixed priority.

When DMA is enabled for a direction, that direction's interrupt is masked. Instead, the block emits a one-cycle DMA request pulse each time the direction's status condition rises. The two flag bits drive the host-visible status word continuously. The data registers, the host bus protocol and the DMA engine lie outside this block.

Top module: `host_irq_ctrl`

## Requirements
- R1: Address 0 is the control word. A write with `bus_wr_en` stores bits 6..0, and reading address 0 returns them with bits 15..7 as zero. Bit 6 is transmit DMA enable, bit 5 is receive DMA enable, bit 4 is flag B, bit 3 is flag A, bit 2 is command interrupt enable, bit 1 is transmit interrupt enable and bit 0 is receive interrupt enable. Without a write to address 0 the control word does not change.
- R2: A clock edge with `rst_n` low clears the control word and all outputs, and loads the command vector with `CMD_VEC_RST` (0x30).
- R3: `host_flags[1]` equals control bit 4 and `host_flags[0]` equals control bit 3, from the cycle after the write.
- R4: Address 1 holds the 8-bit command vector. It reads back with the upper bits zero.
- R5: When `st_cmd_pending` and bit 2 are both 1 at an edge, `irq_req` is 1 after that edge and `irq_vec` equals the command vector. With bit 2 clear, a pending command raises no request.
- R6: A transmit-empty status with bit 1 set and bit 6 clear requests with vector `TX_VEC` (0x21). A receive-full status with bit 0 set and bit 5 clear requests with vector `RX_VEC` (0x22).
- R7: When several sources are enabled and pending, the vector selects the command first, then transmit, then receive.
- R8: A set DMA enable masks that direction's interrupt request, whatever its interrupt enable.
- R9: When (status and DMA enable) of a direction goes from 0 to 1 at an edge, that direction's DMA request is 1 for exactly the following cycle. It stays 0 while the condition holds.
- R10: `irq_req` stays 1 while any enabled source remains pending, and the vector follows the highest remaining one. It drops at the first edge with no enabled pending source. `irq_vec` keeps its last value while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_en | input | 1 | Core register write strobe |
| bus_addr | input | 1 | Register select: 0 control, 1 command vector |
| bus_wdata | input | 16 | Core write data |
| bus_rdata | output | 16 | Read data of the selected register |
| st_cmd_pending | input | 1 | Host command pending status |
| st_tx_empty | input | 1 | Transmit data register empty status |
| st_rx_full | input | 1 | Receive data register full status |
| irq_req | output | 1 | Registered interrupt request to the core |
| irq_vec | output | 8 | Registered vector of the selected source |
| dma_tx_req | output | 1 | One-cycle transmit DMA request |
| dma_rx_req | output | 1 | One-cycle receive DMA request |
| host_flags | output | 2 | Flags shown in the host status word |

## Verification
A corrupted control bit shows within one cycle, either on `bus_rdata` or on `host_flags`. It also shows on `irq_req` and `irq_vec` one edge after a matching status input is applied. A wrong priority choice or a wrong mask appears as a wrong vector, or as a request that should not exist, on the edge after the status changes. A stuck edge detector appears as a missing DMA pulse, or as a pulse that lasts past its single cycle, on the first rise of the condition or on the cycle after it.

// File: rtl/hpi_pkg.sv
// Shared field layout for the host port control word.
// Assumes the control word fits in the low byte of the core data bus.
package hpi_pkg;
    localparam int CTRL_W = 7;

    localparam int BIT_TX_DMA = 6;
    localparam int BIT_RX_DMA = 5;
    localparam int BIT_FLAG_B = 4;
    localparam int BIT_FLAG_A = 3;
    localparam int BIT_CMD_IE = 2;
    localparam int BIT_TX_IE  = 1;
    localparam int BIT_RX_IE  = 0;

    // Source index; a lower index means a higher priority.
    localparam int SRC_CMD = 0;
    localparam int SRC_TX  = 1;
    localparam int SRC_RX  = 2;
    localparam int NSRC    = 3;

    typedef struct packed {
        logic tx_dma;
        logic rx_dma;
        logic flag_b;
        logic flag_a;
        logic cmd_ie;
        logic tx_ie;
        logic rx_ie;
    } ctrl_t;
endpackage

// File: rtl/host_ctrl_regs.sv
// Core-side register file: control word (addr 0) and command vector (addr 1).
// Assumes VEC_W <= DATA_W. Bits outside each register are masked on store,
// so they read back as zero.
module host_ctrl_regs
    import hpi_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int VEC_W = 8,
    parameter logic [VEC_W-1:0] CMD_VEC_RST = 8'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output ctrl_t             ctrl_o,
    output logic [VEC_W-1:0]  cmd_vec_o
);
    localparam logic [DATA_W-1:0] CTRL_MASK = DATA_W'((1 << CTRL_W) - 1);
    localparam logic [DATA_W-1:0] VEC_MASK  = DATA_W'((1 << VEC_W) - 1);

    logic [DATA_W-1:0] ctrl_raw_q;
    logic [DATA_W-1:0] vec_raw_q;

    // Store masked write data into the addressed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_raw_q <= '0;
            vec_raw_q  <= DATA_W'(CMD_VEC_RST);
        end else if (wr_en) begin
            if (addr == 1'b0) ctrl_raw_q <= wdata & CTRL_MASK;
            else              vec_raw_q  <= wdata & VEC_MASK;
        end
    end

    // Return the selected register to the core.
    always_comb begin
        rdata = (addr == 1'b0) ? ctrl_raw_q : vec_raw_q;
    end

    assign ctrl_o    = ctrl_t'(ctrl_raw_q[CTRL_W-1:0]);
    assign cmd_vec_o = vec_raw_q[VEC_W-1:0];
endmodule

// File: rtl/host_irq_arb.sv
// Fixed-priority interrupt selector with registered request and vector.
// Assumes req_i already carries enable and DMA masking; index 0 wins.
// The vector holds its last value while no source requests.
module host_irq_arb #(
    parameter int NSRC = 3,
    parameter int VEC_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NSRC-1:0]            req_i,
    input  logic [NSRC-1:0][VEC_W-1:0] vec_i,
    output logic                       irq_o,
    output logic [VEC_W-1:0]           vec_o
);
    logic [VEC_W-1:0] pick;

    // Walk from lowest to highest priority so the highest pending one wins.
    always_comb begin
        pick = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req_i[i]) pick = vec_i[i];
        end
    end

    // Register the request and, while one exists, its vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            vec_o <= '0;
        end else begin
            irq_o <= |req_i;
            if (|req_i) vec_o <= pick;
        end
    end
endmodule

// File: rtl/host_dma_pulse.sv
// Rising-edge detector: one-cycle registered pulse when cond_i goes 0 -> 1.
// Assumes cond_i is synchronous to clk.
module host_dma_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic cond_i,
    output logic pulse_o
);
    logic prev_q;

    // Remember the condition and pulse on its first cycle only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            pulse_o <= 1'b0;
        end else begin
            prev_q  <= cond_i;
            pulse_o <= cond_i & ~prev_q;
        end
    end
endmodule

// File: rtl/host_irq_ctrl.sv
// Processor-side host port control: register file, interrupt masking,
// fixed-priority request and DMA request pulses.
// Assumes status inputs are synchronous to clk.
module host_irq_ctrl
    import hpi_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int VEC_W = 8,
    parameter logic [VEC_W-1:0] CMD_VEC_RST = 8'h30,
    parameter logic [VEC_W-1:0] TX_VEC = 8'h21,
    parameter logic [VEC_W-1:0] RX_VEC = 8'h22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic              bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              st_cmd_pending,
    input  logic              st_tx_empty,
    input  logic              st_rx_full,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec,
    output logic              dma_tx_req,
    output logic              dma_rx_req,
    output logic [1:0]        host_flags
);
    localparam int NDMA = 2;

    ctrl_t                      ctrl_q;
    logic [VEC_W-1:0]           cmd_vec_q;
    logic [NSRC-1:0]            src_req;
    logic [NSRC-1:0][VEC_W-1:0] src_vec;
    logic [NDMA-1:0]            dma_cond;
    logic [NDMA-1:0]            dma_pulse;

    host_ctrl_regs #(
        .DATA_W(DATA_W), .VEC_W(VEC_W), .CMD_VEC_RST(CMD_VEC_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr_en), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata),
        .ctrl_o(ctrl_q), .cmd_vec_o(cmd_vec_q)
    );

    // Combine status with enables; DMA mode masks the data interrupts.
    always_comb begin
        src_req[SRC_CMD] = st_cmd_pending & ctrl_q.cmd_ie;
        src_req[SRC_TX]  = st_tx_empty & ctrl_q.tx_ie & ~ctrl_q.tx_dma;
        src_req[SRC_RX]  = st_rx_full & ctrl_q.rx_ie & ~ctrl_q.rx_dma;
        src_vec[SRC_CMD] = cmd_vec_q;
        src_vec[SRC_TX]  = TX_VEC;
        src_vec[SRC_RX]  = RX_VEC;
        dma_cond[0]      = st_tx_empty & ctrl_q.tx_dma;
        dma_cond[1]      = st_rx_full & ctrl_q.rx_dma;
    end

    host_irq_arb #(.NSRC(NSRC), .VEC_W(VEC_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .req_i(src_req), .vec_i(src_vec),
        .irq_o(irq_req), .vec_o(irq_vec)
    );

    for (genvar g = 0; g < NDMA; g++) begin : g_dma
        host_dma_pulse u_pulse (
            .clk(clk), .rst_n(rst_n), .cond_i(dma_cond[g]), .pulse_o(dma_pulse[g])
        );
    end

    assign dma_tx_req = dma_pulse[0];
    assign dma_rx_req = dma_pulse[1];
    assign host_flags = {ctrl_q.flag_b, ctrl_q.flag_a};
endmodule

// File: rtl/host_irq_ctrl_chk.sv
// Property checker for host_irq_ctrl, attached by bind below.
module host_irq_ctrl_chk #(
    parameter int DATA_W = 16,
    parameter int VEC_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr_en,
    input logic              bus_addr,
    input logic [1:0]        wr_flags,
    input logic [DATA_W-8:0] rdata_hi,
    input logic              st_cmd_pending,
    input logic              st_tx_empty,
    input logic              st_rx_full,
    input logic              irq_req,
    input logic [VEC_W-1:0]  irq_vec,
    input logic              dma_tx_req,
    input logic              dma_rx_req,
    input logic [1:0]        host_flags,
    input logic [6:0]        ctrl,
    input logic [VEC_W-1:0]  cmd_vec
);
    logic any_src;
    assign any_src = (st_cmd_pending & ctrl[2]) | (st_tx_empty & ctrl[1] & ~ctrl[6])
                   | (st_rx_full & ctrl[0] & ~ctrl[5]);

    // R2
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (ctrl == '0 && !irq_req && !dma_tx_req && !dma_rx_req));

    // R1
    rdata_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 1'b0) |-> (rdata_hi == '0));

    // R1
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr_en && bus_addr == 1'b0) |=> $stable(ctrl));

    // R3
    flag_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_en && bus_addr == 1'b0) |=> (host_flags == $past(wr_flags)));

    // R5
    cmd_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_cmd_pending && ctrl[2]) |=> (irq_req && irq_vec == $past(cmd_vec)));

    // R8
    dma_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[6] && ctrl[5] && !(st_cmd_pending && ctrl[2])) |=> !irq_req);

    // R9
    tx_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_tx_req |=> !dma_tx_req);

    // R9
    rx_pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rx_req |=> !dma_rx_req);

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_src |=> irq_req);

    // R10
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_src |=> !irq_req);
endmodule

bind host_irq_ctrl host_irq_ctrl_chk #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
    .wr_flags(bus_wdata[4:3]), .rdata_hi(bus_rdata[DATA_W-1:7]),
    .st_cmd_pending(st_cmd_pending), .st_tx_empty(st_tx_empty), .st_rx_full(st_rx_full),
    .irq_req(irq_req), .irq_vec(irq_vec), .dma_tx_req(dma_tx_req), .dma_rx_req(dma_rx_req),
    .host_flags(host_flags), .ctrl(ctrl_q), .cmd_vec(cmd_vec_q)
);

// File: tb/tb_host_irq_ctrl.sv
module tb_host_irq_ctrl;
    localparam logic [7:0] CMDV = 8'h5A;
    localparam logic [7:0] TXV  = 8'h21;
    localparam logic [7:0] RXV  = 8'h22;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr_en = 1'b0;
    logic bus_addr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic st_cmd_pending = 1'b0, st_tx_empty = 1'b0, st_rx_full = 1'b0;
    logic irq_req, dma_tx_req, dma_rx_req;
    logic [7:0] irq_vec;
    logic [1:0] host_flags;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    host_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .st_cmd_pending(st_cmd_pending), .st_tx_empty(st_tx_empty), .st_rx_full(st_rx_full),
        .irq_req(irq_req), .irq_vec(irq_vec), .dma_tx_req(dma_tx_req),
        .dma_rx_req(dma_rx_req), .host_flags(host_flags)
    );

    // {ctrl[6:0], status {cmd,tx,rx}, exp irq, exp src (0 cmd,1 tx,2 rx), exp dma tx, exp dma rx}
    localparam logic [14:0] VECS [12] = '{
        {7'b0000100, 3'b100, 1'b1, 2'd0, 1'b0, 1'b0},   // R5
        {7'b0000000, 3'b111, 1'b0, 2'd0, 1'b0, 1'b0},   // R5 suppressed
        {7'b0000111, 3'b111, 1'b1, 2'd0, 1'b0, 1'b0},   // R7
        {7'b0000011, 3'b011, 1'b1, 2'd1, 1'b0, 1'b0},   // R7
        {7'b0000001, 3'b011, 1'b1, 2'd2, 1'b0, 1'b0},   // R6
        {7'b0000010, 3'b001, 1'b0, 2'd0, 1'b0, 1'b0},   // R6
        {7'b1000011, 3'b011, 1'b1, 2'd2, 1'b1, 1'b0},   // R8
        {7'b1100011, 3'b011, 1'b0, 2'd0, 1'b1, 1'b1},   // R8
        {7'b0100111, 3'b001, 1'b0, 2'd0, 1'b0, 1'b1},   // R9
        {7'b1000111, 3'b110, 1'b1, 2'd0, 1'b1, 1'b0},   // R7
        {7'b0000110, 3'b010, 1'b1, 2'd1, 1'b0, 1'b0},   // R6
        {7'b0000101, 3'b001, 1'b1, 2'd2, 1'b0, 1'b0}    // R6
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr_en = 1'b0; bus_addr = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [15:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
        bus_addr = 1'b0;
    endtask

    task automatic set_st(input logic [2:0] s);
        {st_cmd_pending, st_tx_empty, st_rx_full} = s;
    endtask

    initial begin
        #(8 * 20000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [15:0] d;
        logic [7:0] ev;
        repeat (3) @(negedge clk);
        // R2 reset state
        rd(1'b0, d); chk(d == 16'h0, "R2 ctrl", d, 16'h0);
        rd(1'b1, d); chk(d == 16'h0030, "R2 vec", d, 16'h0030);
        chk({irq_req, dma_tx_req, dma_rx_req, host_flags} == '0, "R2 outputs",
            {irq_req, dma_tx_req, dma_rx_req, host_flags}, 0);
        rst_n = 1'b1;

        // R1 upper bits read as zero
        wr(1'b0, 16'hFFFF);
        rd(1'b0, d); chk(d == 16'h007F, "R1 readback", d, 16'h007F);
        // R3 flags mirrored
        chk(host_flags == 2'b11, "R3 flags", host_flags, 2'b11);
        wr(1'b0, 16'h0010);
        chk(host_flags == 2'b10, "R3 flag b only", host_flags, 2'b10);
        wr(1'b0, 16'h0008);
        chk(host_flags == 2'b01, "R3 flag a only", host_flags, 2'b01);
        // R4 command vector
        wr(1'b1, 16'hFF00 | 16'(CMDV));
        rd(1'b1, d); chk(d == 16'(CMDV), "R4 vec readback", d, 16'(CMDV));
        rd(1'b0, d); chk(d == 16'h0008, "R1 ctrl unchanged by vec write", d, 16'h0008);

        // Table walk: R5 R6 R7 R8 R9
        foreach (VECS[i]) begin
            wr(1'b0, 16'(VECS[i][14:8]));
            set_st(VECS[i][7:5]);
            @(negedge clk);
            chk(irq_req == VECS[i][4], "R5-table irq", irq_req, VECS[i][4]);
            if (VECS[i][4]) begin
                ev = (VECS[i][3:2] == 2'd0) ? CMDV : (VECS[i][3:2] == 2'd1) ? TXV : RXV;
                chk(irq_vec == ev, "R7 vector", irq_vec, ev);
            end
            chk(dma_tx_req == VECS[i][1], "R9 dma tx", dma_tx_req, VECS[i][1]);
            chk(dma_rx_req == VECS[i][0], "R9 dma rx", dma_rx_req, VECS[i][0]);
            set_st(3'b000);
        end

        // R9 pulse lasts one cycle while condition held
        wr(1'b0, 16'h0042);
        set_st(3'b010);
        @(negedge clk);
        chk(dma_tx_req == 1'b1, "R9 pulse", dma_tx_req, 1);
        chk(irq_req == 1'b0, "R8 masked tx", irq_req, 0);
        @(negedge clk);
        chk(dma_tx_req == 1'b0, "R9 single cycle", dma_tx_req, 0);
        @(negedge clk);
        chk(dma_tx_req == 1'b0, "R9 no repeat", dma_tx_req, 0);
        set_st(3'b000);

        // R10 persistence and fall-through
        wr(1'b0, 16'h0006);
        set_st(3'b110);
        repeat (3) begin
            @(negedge clk);
            chk(irq_req && irq_vec == CMDV, "R10 held", {irq_req, irq_vec}, {1'b1, CMDV});
        end
        set_st(3'b010);
        @(negedge clk);
        chk(irq_req && irq_vec == TXV, "R10 next source", {irq_req, irq_vec}, {1'b1, TXV});
        set_st(3'b000);
        @(negedge clk);
        chk(irq_req == 1'b0, "R10 drop", irq_req, 0);
        chk(irq_vec == TXV, "R10 vec hold", irq_vec, TXV);

        // R2 reset mid-run
        wr(1'b0, 16'h007F);
        rst_n = 1'b0;
        @(negedge clk);
        rd(1'b0, d); chk(d == 16'h0, "R2 ctrl after reset", d, 0);
        rd(1'b1, d); chk(d == 16'h0030, "R2 vec after reset", d, 16'h0030);
        rst_n = 1'b1;

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule